// File: doc/BRIEF.md
# Transition-to-return-to-zero handshake converter

This controller sits between a sender that signals by transitions (every change of level on its request line is one event) and an arbiter that expects a return-to-zero request/grant exchange. For each change on the transition-signalled input, in either direction, the block runs one complete four-phase exchange with the arbiter. It also flips a toggle output that the local logic can sample safely.

The block is modelled in a sampled synchronous domain. Six states form a ring. Three of them serve a rising input edge and three serve a falling one. At the moment the grant is seen, the internal request is withdrawn and the toggle output takes the new input level, both in the same step. Because the controller compares the input level with its progress around the ring, an input edge that arrives while an exchange is still in progress is kept. It is served once the ring reaches the state that waits for it.

Top module: `edge_handshake_conv`

## Requirements
- R1: While rst_n is low, both outputs are low and the controller is idle, waiting for a rising edge on ev_in.
- R2: When idle and ev_in differs from sync_tog, arb_req goes high one clock after the new level is sampled, and sync_tog keeps its value.
- R3: When arb_gnt is sampled high while arb_req is high, in the next cycle arb_req is low and sync_tog equals the level that started the exchange. Both changes happen in the same cycle.
- R4: arb_req stays high for as long as arb_gnt is sampled low.
- R5: After a grant, no new request is raised until arb_gnt has been sampled low, even if ev_in has already changed again.
- R6: A falling edge of ev_in is served like a rising one. arb_req makes one high pulse, and sync_tog falls when the grant is seen.
- R7: sync_tog changes only in the cycle after a grant is observed with arb_req high. Each ev_in edge produces exactly one sync_tog edge.
- R8: An ev_in edge that arrives while a request is outstanding or a grant is still high is held. It is served after the current exchange ends.
- R9: arb_gnt pulses while the controller is idle do not change either output.
- R10: While ev_in equals sync_tog, no request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_in | input | 1 | Transition-signalled request; every level change is one event |
| arb_gnt | input | 1 | Grant from the arbiter (four-phase) |
| arb_req | output | 1 | Request to the arbiter (four-phase) |
| sync_tog | output | 1 | Toggle output that follows ev_in once each exchange has been granted |

## Verification
The converter is driven with isolated rising and falling edges of ev_in. These separate the two halves of the ring and confirm that the request is withdrawn and the toggle moves in the same cycle. A grant held back for several cycles shows that the request persists until it is granted. An input that reverses while the grant is still high, and one that reverses before the grant arrives, show whether pending edges are held rather than lost or merged. Grant pulses while idle and a static input confirm that nothing starts without an input edge. A running count of toggle edges against input edges confirms the one-to-one mapping.

// File: rtl/edge_handshake_conv.sv
`timescale 1ns/1ps
module edge_handshake_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_in,
  input  logic arb_gnt,
  output logic arb_req,
  output logic sync_tog
);

  typedef enum logic [2:0] {
    RISE_IDLE = 3'd0,
    RISE_REQ  = 3'd1,
    RISE_GNT  = 3'd2,
    FALL_IDLE = 3'd3,
    FALL_REQ  = 3'd4,
    FALL_GNT  = 3'd5
  } ring_t;

  ring_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      RISE_IDLE: if (ev_in)    st_nx = RISE_REQ;
      RISE_REQ:  if (arb_gnt)  st_nx = RISE_GNT;
      RISE_GNT:  if (!arb_gnt) st_nx = FALL_IDLE;
      FALL_IDLE: if (!ev_in)   st_nx = FALL_REQ;
      FALL_REQ:  if (arb_gnt)  st_nx = FALL_GNT;
      FALL_GNT:  if (!arb_gnt) st_nx = RISE_IDLE;
      default:                 st_nx = RISE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= RISE_IDLE;
    else        st <= st_nx;

  assign arb_req  = (st == RISE_REQ) || (st == FALL_REQ);
  assign sync_tog = (st == RISE_GNT) || (st == FALL_IDLE) || (st == FALL_REQ);

endmodule

module edge_handshake_conv_chk (
  input logic clk,
  input logic rst_n,
  input logic ev_in,
  input logic arb_gnt,
  input logic arb_req,
  input logic sync_tog
);

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (!arb_req && !sync_tog));

  a_r2_req_needs_diff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_req) |-> ($past(ev_in) != sync_tog) && $stable(sync_tog));

  a_r3_drop_and_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && arb_gnt) |=> (!arb_req && (sync_tog != $past(sync_tog))));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && !arb_gnt) |=> arb_req);

  a_r7_tog_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_tog != $past(sync_tog)) |-> $past(arb_req && arb_gnt));

endmodule

bind edge_handshake_conv edge_handshake_conv_chk u_chk (.*);

// File: tb/sim_edge_handshake_conv.sv
`timescale 1ns/1ps
module sim_edge_handshake_conv;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_in = 1'b0;
  logic arb_gnt = 1'b0;
  logic arb_req, sync_tog;

  int n_chk = 0, n_bad = 0;
  int ev_edges = 0, tog_edges = 0;
  logic tog_prev = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  edge_handshake_conv u0 (.*);

  always @(negedge clk) begin
    if (rst_n && sync_tog != tog_prev) tog_edges++;
    tog_prev = sync_tog;
  end

  task automatic chk(input string rq, input logic r, input logic t,
                     input logic er, input logic et);
    n_chk++;
    if (r !== er || t !== et) begin
      n_bad++;
      $display("FAIL %s: req=%b tog=%b expected req=%b tog=%b", rq, r, t, er, et);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    chk("R1", arb_req, sync_tog, 0, 0);
    rst_n = 1; step();
    chk("R1", arb_req, sync_tog, 0, 0);
  endtask

  task automatic t_edge(input logic lvl, input string rq);
    ev_in = lvl; ev_edges++; step();
    chk(rq, arb_req, sync_tog, 1, !lvl);
    repeat (3) step();
    chk("R4", arb_req, sync_tog, 1, !lvl);
    arb_gnt = 1; step();
    chk("R3", arb_req, sync_tog, 0, lvl);
    step();
    chk("R5", arb_req, sync_tog, 0, lvl);
    arb_gnt = 0; step();
    chk(rq, arb_req, sync_tog, 0, lvl);
    step();
  endtask

  task automatic t_idle_noise();
    arb_gnt = 1; step(); step();
    chk("R9", arb_req, sync_tog, 0, ev_in);
    arb_gnt = 0; repeat (4) step();
    chk("R10", arb_req, sync_tog, 0, ev_in);
  endtask

  task automatic t_held_during_grant();
    ev_in = 1; ev_edges++; step();
    arb_gnt = 1; step();
    chk("R3", arb_req, sync_tog, 0, 1);
    ev_in = 0; ev_edges++; repeat (3) step();
    chk("R5", arb_req, sync_tog, 0, 1);
    arb_gnt = 0; step();
    chk("R8", arb_req, sync_tog, 0, 1);
    step();
    chk("R8", arb_req, sync_tog, 1, 1);
    arb_gnt = 1; step();
    chk("R6", arb_req, sync_tog, 0, 0);
    arb_gnt = 0; step(); step();
  endtask

  task automatic t_reverse_before_grant();
    ev_in = 1; ev_edges++; step();
    chk("R2", arb_req, sync_tog, 1, 0);
    ev_in = 0; ev_edges++; step();
    chk("R8", arb_req, sync_tog, 1, 0);
    arb_gnt = 1; step();
    chk("R3", arb_req, sync_tog, 0, 1);
    arb_gnt = 0; step(); step();
    chk("R8", arb_req, sync_tog, 1, 1);
    arb_gnt = 1; step();
    chk("R6", arb_req, sync_tog, 0, 0);
    arb_gnt = 0; step(); step();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    step();
    t_reset();
    chk("R10", arb_req, sync_tog, 0, 0);
    t_edge(1, "R2");
    t_edge(0, "R6");
    t_idle_noise();
    t_held_during_grant();
    t_reverse_before_grant();
    t_edge(1, "R2");
    t_idle_noise();
    t_edge(0, "R6");
    step();
    n_chk++;
    if (tog_edges != ev_edges) begin
      n_bad++;
      $display("FAIL R7: toggle edges=%0d expected %0d", tog_edges, ev_edges);
    end
    done = 1;
    finish_run();
  end

  initial begin
    #20000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: done=0 expected 1");
      finish_run();
    end
  end

endmodule